// File: doc/BRIEF.md
# Ring-Buffer Trigger Capture Controller

This controller turns a continuous stream of samples into a single frozen window that surrounds a trigger. While armed, it writes every valid sample into a circular RAM. The write pointer wraps at a programmable window length, so old history is overwritten without limit. When a trigger is accepted, the controller writes a programmed number of further samples and then stops writing. It raises a ready flag and holds the RAM address of the final write.

A reader can then fetch the window starting one address past the held stop address, wrapping at the window length. The oldest sample comes out first, and the trigger sample always sits at index `total - post`. For example, a window of 2000 samples with 1600 post-trigger samples places the trigger at index 400.

The controller accepts no trigger until the pre-trigger part of the window has been filled with fresh samples since arming. Once the reader pulses its done input, the controller re-arms. On re-arming, the pointer returns to address 0.

Top module: `ring_capture_ctrl`

## Requirements
- R1: After a synchronous reset, `wr_en`, `cap_ready` and `stop_addr` are all 0, and the first capture writes its first sample at address 0.
- R2: While armed or post-capturing, each sample with `smp_valid` high appears on the write port one cycle later. Its address is one above the previous write, and the address wraps from `total_len-1` to 0.
- R3: A trigger is ignored unless at least `total_len - post_eff` samples have been written since reset or re-arm.
- R4: An accepted trigger must arrive together with a valid sample. That sample is the first of the post-trigger samples. Exactly `post_eff` samples are written, counting the trigger sample, and then writing stops.
- R5: `cap_ready` rises in the same cycle in which the final post-trigger write appears on the write port. At that point `stop_addr` equals the address of that write.
- R6: In the window read from `(stop_addr+1+i) mod total_len`, the trigger sample is found at index `i = total_len - post_eff`.
- R7: While `cap_ready` is high, the following have no effect: no write occurs, `stop_addr` holds, and `cap_ready` stays high even when samples and triggers arrive.
- R8: A `rd_done` pulse while `cap_ready` is high does three things: it clears `cap_ready` on the next cycle, it restarts addressing at 0, and it makes the pre-trigger fill requirement start again from zero.
- R9: `post_eff` equals `post_len` clamped to `total_len`. A `post_len` of 0 is treated as 1.
- R10: The following triggers are dropped: a trigger in a cycle without a valid sample, and a trigger during post-trigger acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | DATA_W | Sample value |
| smp_valid | input | 1 | Sample present this cycle |
| trig | input | 1 | Trigger pulse |
| total_len | input | AW+1 | Window length, 1..2**AW |
| post_len | input | AW+1 | Requested post-trigger sample count |
| rd_done | input | 1 | Reader finished, re-arm |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | AW | RAM write address |
| wr_data | output | DATA_W | RAM write data |
| cap_ready | output | 1 | Capture complete, window frozen |
| stop_addr | output | AW | Address of the last sample written |

## Verification
The assertions make two assumptions about the inputs. First, `total_len` lies between 1 and the RAM depth. Second, `total_len` and `post_len` do not change while the controller is armed or collecting post-trigger samples, so every write address stays below the window length. The stimulus respects this: it programs new lengths only before the first capture or while `cap_ready` is high, and then pulses `rd_done`. Triggers arriving on idle cycles, during post-trigger acquisition and while the window is frozen are injected on purpose, because each of them must be dropped.

// File: rtl/ring_capture_pkg.sv
package ring_capture_pkg;
  typedef enum logic [1:0] {
    CAP_ARM  = 2'd0,
    CAP_POST = 2'd1,
    CAP_HOLD = 2'd2
  } cap_state_t;
endpackage

// File: rtl/rc_window_calc.sv
// Derives the effective post-trigger count and the pre-trigger length.
module rc_window_calc #(
  parameter int AW = 12
) (
  input  logic [AW:0] total_len,
  input  logic [AW:0] post_len,
  output logic [AW:0] post_eff,
  output logic [AW:0] pre_len
);
  localparam logic [AW:0] ONE = 1;

  always_comb begin
    if (post_len == '0)             post_eff = ONE;       // R9 floor
    else if (post_len > total_len)  post_eff = total_len; // R9 clamp
    else                            post_eff = post_len;
    pre_len = total_len - post_eff;
  end

  always_comb begin
    a_r9_post_within_total: assert (total_len == '0 || (post_eff <= total_len && post_eff != '0));
  end
endmodule

// File: rtl/rc_wr_ptr.sv
// Circular write pointer, wraps at the programmed window length.
module rc_wr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [AW:0]   total_len,
  output logic [AW-1:0] ptr
);
  logic [AW:0] nxt;
  assign nxt = {1'b0, ptr} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr <= '0;
    else if (adv)    ptr <= (nxt >= total_len) ? '0 : nxt[AW-1:0];
  end
endmodule

// File: rtl/rc_fill_cnt.sv
// Counts samples written since arming, saturating at the pre-trigger length.
module rc_fill_cnt #(
  parameter int AW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        inc,
  input  logic [AW:0] pre_len,
  output logic        pre_ok
);
  logic [AW:0] fill;

  always_ff @(posedge clk) begin
    if (rst || clr)                 fill <= '0;
    else if (inc && fill < pre_len) fill <= fill + 1'b1;
  end

  assign pre_ok = (fill >= pre_len);

  a_r8_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clr |=> fill == '0);
endmodule

// File: rtl/rc_seq.sv
// Capture sequencer: armed -> post-trigger -> hold.
module rc_seq
  import ring_capture_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic          trig,
  input  logic          ack,
  input  logic          pre_ok,
  input  logic [AW:0]   post_eff,
  input  logic [AW-1:0] ptr,
  output logic          write,
  output logic          fill_inc,
  output logic          rearm,
  output logic          ready,
  output logic [AW-1:0] stop_addr
);
  localparam logic [AW:0] ONE = 1;

  cap_state_t  state, state_n;
  logic [AW:0] post_cnt, cnt_next;
  logic        accept, finish;

  assign write    = smp_valid && (state != CAP_HOLD);
  assign accept   = (state == CAP_ARM) && write && trig && pre_ok;
  assign cnt_next = post_cnt + 1'b1;
  assign finish   = (accept && post_eff == ONE) ||
                    ((state == CAP_POST) && write && cnt_next == post_eff);
  assign rearm    = (state == CAP_HOLD) && ack;
  assign fill_inc = (state == CAP_ARM) && write;

  always_comb begin
    state_n = state;
    unique case (state)
      CAP_ARM:  if (accept) state_n = (post_eff == ONE) ? CAP_HOLD : CAP_POST;
      CAP_POST: if (finish) state_n = CAP_HOLD;
      CAP_HOLD: if (ack)    state_n = CAP_ARM;
      default:              state_n = CAP_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_ARM;
      post_cnt  <= '0;
      ready     <= 1'b0;
      stop_addr <= '0;
    end else begin
      state <= state_n;
      if (accept)                              post_cnt <= ONE;
      else if (state == CAP_POST && write)     post_cnt <= cnt_next;
      if (finish) begin
        ready     <= 1'b1;
        stop_addr <= ptr;
      end else if (rearm) begin
        ready     <= 1'b0;
      end
    end
  end

  a_r4_post_count_bound: assert property (@(posedge clk) disable iff (rst)
    state == CAP_POST |-> (post_cnt != '0 && post_cnt < post_eff));
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ready && ack |=> !ready && state == CAP_ARM);
  a_r7_hold_means_ready: assert property (@(posedge clk) disable iff (rst)
    state == CAP_HOLD |-> ready);
endmodule

// File: rtl/ring_capture_ctrl.sv
// Top: circular pre/post-trigger capture controller.
module ring_capture_ctrl #(
  parameter int AW     = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic              trig,
  input  logic [AW:0]       total_len,
  input  logic [AW:0]       post_len,
  input  logic              rd_done,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cap_ready,
  output logic [AW-1:0]     stop_addr
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = DEPTH;
  localparam logic [AW-1:0] A_ONE = 1;

  logic [AW:0]   post_eff, pre_len;
  logic [AW-1:0] ptr;
  logic          write, fill_inc, rearm, pre_ok;

  rc_window_calc #(.AW(AW)) u_win (
    .total_len(total_len), .post_len(post_len),
    .post_eff(post_eff), .pre_len(pre_len));

  rc_wr_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .clr(rearm), .adv(write),
    .total_len(total_len), .ptr(ptr));

  rc_fill_cnt #(.AW(AW)) u_fill (
    .clk(clk), .rst(rst), .clr(rearm), .inc(fill_inc),
    .pre_len(pre_len), .pre_ok(pre_ok));

  rc_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .trig(trig), .ack(rd_done),
    .pre_ok(pre_ok), .post_eff(post_eff), .ptr(ptr),
    .write(write), .fill_inc(fill_inc), .rearm(rearm),
    .ready(cap_ready), .stop_addr(stop_addr));

  // Registered RAM write port
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= write;
      wr_addr <= ptr;
      wr_data <= smp_data;
    end
  end

  a_r2_total_legal: assert property (@(posedge clk) disable iff (rst)
    total_len != '0 && total_len <= DEPTH_V);
  a_r2_addr_in_window: assert property (@(posedge clk) disable iff (rst)
    wr_en && !cap_ready |-> {1'b0, wr_addr} < total_len);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    wr_en && $past(wr_en) |-> (wr_addr == $past(wr_addr) + A_ONE || wr_addr == '0));
  a_r5_stop_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_ready) |-> wr_en && stop_addr == wr_addr);
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    cap_ready && $past(cap_ready) |-> !wr_en && $stable(stop_addr));
endmodule

// File: tb/ring_capture_ctrl_test.sv
module ring_capture_ctrl_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NV = 6;
  // total, post, early trigger (-1 none), trigger index, gap mode
  localparam int VEC [0:NV-1][0:4] = '{
    '{2000, 1600,  100,  450, 0},
    '{  16,    4,    5,   20, 1},
    '{  10,   25,   -1,    0, 0},
    '{   8,    0,   -1,    9, 1},
    '{4096,    1, 3000, 4095, 0},
    '{   5,    5,   -1,    2, 1}
  };

  logic clk = 0, rst = 1;
  logic [DW-1:0] smp_data = '0;
  logic smp_valid = 0, trig = 0, rd_done = 0;
  logic [AW:0] total_len = 13'd8, post_len = 13'd4;
  logic wr_en, cap_ready;
  logic [AW-1:0] wr_addr, stop_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int total_cnt = 0, bad_cnt = 0;

  always #5 clk = ~clk;

  ring_capture_ctrl #(.AW(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .trig(trig), .total_len(total_len), .post_len(post_len), .rd_done(rd_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_ready(cap_ready), .stop_addr(stop_addr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(input int k, input int seed);
    return DW'(k * 7 + seed * 13);
  endfunction

  task automatic capture(input int tot, input int pst, input int early,
                         input int tat, input int gap, input int seed);
    int pe, pre, sent, wcount, aerr, stop_exp, guard;
    bit idle_ph;
    pe  = (pst == 0) ? 1 : (pst > tot ? tot : pst);
    pre = tot - pe;
    @(negedge clk);
    total_len = 13'(tot);
    post_len  = 13'(pst);
    if (cap_ready) begin
      rd_done = 1;
      @(negedge clk);
      rd_done = 0;
      check(!cap_ready, "R8 ready cleared by done", int'(cap_ready), 0);
    end
    sent = 0; wcount = 0; aerr = 0; guard = 0; idle_ph = 0;
    smp_valid = 0; trig = 0;
    forever begin
      @(negedge clk);
      if (wr_en) begin
        mem[wr_addr] = wr_data;
        if (int'(wr_addr) != wcount % tot || wr_data != dat(wcount, seed)) aerr++;
        wcount++;
      end
      if (cap_ready) break;
      guard++;
      if (guard > tat + pe + 40 + 2 * tot) break;
      if (gap != 0 && idle_ph) begin
        smp_valid = 0;
        trig = 1;                       // R10: trigger without a sample
      end else begin
        smp_valid = 1;
        smp_data  = dat(sent, seed);
        trig = (sent == early) || (sent == tat) || (sent == tat + 1); // R10: tat+1 in post
        sent++;
      end
      idle_ph = !idle_ph;
    end
    smp_valid = 0; trig = 0;
    stop_exp = (tat + pe - 1) % tot;
    check(sent == tat + pe, "R4 samples until ready", sent, tat + pe);
    check(aerr == 0 && wcount == sent, "R2 write addresses and data", aerr, 0);
    check(int'(stop_addr) == stop_exp, "R5 stop address", int'(stop_addr), stop_exp);
    check(mem[(stop_exp + 1 + pre) % tot] == dat(tat, seed), "R6 trigger index",
          int'(mem[(stop_exp + 1 + pre) % tot]), int'(dat(tat, seed)));
    if (early >= 0) check(sent == tat + pe, "R3 early trigger ignored", sent, tat + pe);
    if (pst == 0 || pst > tot) check(sent == tat + pe, "R9 clamped post count", sent, tat + pe);
    if (gap != 0) check(sent == tat + pe, "R10 stray triggers dropped", sent, tat + pe);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total_cnt++; bad_cnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin : main
    int saved, errs;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!wr_en && !cap_ready && stop_addr == '0, "R1 reset state",
          int'({wr_en, cap_ready}) + int'(stop_addr), 0);

    for (int v = 0; v < NV; v++)
      capture(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], v + 1);

    // R7: frozen window ignores samples and triggers
    saved = int'(stop_addr); errs = 0;
    for (int k = 0; k < 6; k++) begin
      smp_valid = 1; trig = 1; smp_data = 16'hbeef;
      @(negedge clk);
      if (wr_en || !cap_ready || int'(stop_addr) != saved) errs++;
    end
    smp_valid = 0; trig = 0;
    check(errs == 0, "R7 hold ignores input", errs, 0);

    // R8 + R3: after re-arm the fill restarts; ring previously full
    capture(6, 2, 3, 4, 0, 9);

    // R1: reset mid-hold clears flag and address
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!cap_ready && !wr_en && stop_addr == '0, "R1 reset in hold",
          int'(cap_ready), 0);
    capture(4, 2, -1, 2, 0, 11);

    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end
endmodule